// File: doc/BRIEF.md
# Console Transmit Port

This block is the transmit half of a console serial line, seen by software as two 16-bit words on a simple memory-mapped bus. Address bit 1 selects the word: 0 is the control/status word and 1 is the data buffer. Writing the buffer word starts a transfer of one byte. The byte goes to a downstream serial transmitter over a valid/ready handshake. When the transmitter takes the byte, the port raises its done flag and, if interrupts are enabled, an interrupt request. It also counts every completed character.

Before the byte is presented, it passes through one of four output conversions, chosen by the `out_mode` input:
- 7-bit with parity passthrough: the byte goes out unchanged, but null and delete fillers are dropped without being sent.
- 7-bit: the top bit is cleared.
- 8-bit: the byte goes out unchanged.
- Upper-case only: the top bit is cleared and lower-case letters are folded to capitals.

Sequencing is handled by a three-state machine:
- IDLE: nothing in flight.
- CONV: one cycle that registers the converted byte.
- SEND: `tx_valid` is high until `tx_ready`.

The machine has these transitions:
- start (any state to CONV on a buffer write)
- present (CONV to SEND)
- drop (CONV to IDLE for a suppressed filler)
- accept (SEND to IDLE when `tx_ready` is high)

A start always wins, so a buffer write during SEND re-enters CONV.

Top module: `console_tx_port`

## Requirements
- R1: Reads are side-effect free. With `bus_addr[1]`=0, `bus_rdata` holds done at bit 7 and interrupt enable at bit 6, with all other bits 0. With `bus_addr[1]`=1, `bus_rdata[7:0]` is the last byte loaded into the buffer and bits 15:8 are 0.
- R2: After reset, the following hold: done=1, enable=0, `irq`=0, buffer=0, `tx_valid`=0 and `sent_count`=0.
- R3: In a control/status write, only bit 6 (enable) is stored; done cannot be written. A write with `bus_addr[0]`=1 (odd byte) to the control/status word changes nothing.
- R4: Writing enable=0 drops `irq`. Writing enable=1 while done=1 and enable was 0 raises `irq`.
- R5: A buffer write with `bus_addr[0]`=0 loads `bus_wdata[7:0]`; one with `bus_addr[0]`=1 leaves the byte unchanged. Either one clears done and `irq` on the next edge and starts a transfer.
- R6: `tx_valid` rises on the second edge after the buffer write. While `tx_ready` is 0 and no new buffer write arrives, `tx_valid` and `tx_data` hold.
- R7: On the edge where `tx_valid` and `tx_ready` are both 1, the following happen: done sets, `irq` follows enable, `sent_count` increments and `tx_valid` falls.
- R8: With `out_mode`=2'b10 (8-bit), `tx_data` equals the byte. With `out_mode`=2'b01 (7-bit), `tx_data` equals the byte with bit 7 cleared.
- R9: With `out_mode`=2'b11 (upper case), bit 7 is cleared, and codes 0x61 to 0x7A then have 0x20 subtracted.
- R10: With `out_mode`=2'b00 (7-bit with parity passthrough), the byte goes out unchanged. A byte whose low 7 bits are 0x00 or 0x7F is never presented: done sets and `sent_count` increments on the second edge after the write.
- R11: A buffer write while a byte is pending and not yet accepted replaces it. `tx_valid` drops for one cycle, the new byte is then presented, and only one completion is counted.
- R12: Reset during a transfer aborts it: `tx_valid` falls and the R2 state returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when 1 |
| bus_addr | input | 2 | Bit 1 selects the word, bit 0 marks an odd-byte write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| out_mode | input | 2 | Output conversion mode |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_data | output | 8 | Converted byte |
| irq | output | 1 | Interrupt request |
| sent_count | output | CNT_W | Completed characters |

## Verification
The bench sweeps all 256 byte values through all four modes and computes the expected character arithmetically. A converter that folded the wrong range or cleared the wrong bit would send a visibly wrong byte. A converter that suppressed the wrong fillers would either present a byte that should vanish, or hang with done low. The enable rules are driven at the edges where a design would falsely raise `irq` on a repeated enable write, or leave it high after a buffer write. An odd-byte buffer write is checked to resend the old byte unchanged. A replacement during stall is checked to send only the new byte and count it once. A reset in mid-transfer is checked to leave `tx_valid` high if the abort were missing.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int DONE_BIT = 7;
    localparam int IE_BIT   = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_SEND = 2'd2
    } ctx_state_e;

    typedef enum logic [1:0] {
        MODE_7P = 2'b00,
        MODE_7B = 2'b01,
        MODE_8B = 2'b10,
        MODE_UC = 2'b11
    } ctx_mode_e;
endpackage

// File: rtl/ctx_convert.sv
module ctx_convert
    import ctx_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  ctx_mode_e         mode_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              suppress_o
);
    logic [BYTE_W-2:0] low7;
    logic              is_lower;

    assign low7     = byte_i[BYTE_W-2:0];
    assign is_lower = (low7 >= 7'h61) && (low7 <= 7'h7A);

    always_comb begin
        byte_o     = byte_i;
        suppress_o = 1'b0;
        unique case (mode_i)
            MODE_7P: suppress_o = (low7 == 7'h00) || (low7 == 7'h7F);
            MODE_7B: byte_o = {1'b0, low7};
            MODE_8B: byte_o = byte_i;
            MODE_UC: begin
                byte_o = {1'b0, low7};
                if (is_lower) byte_o[5] = 1'b0;
            end
            default: byte_o = byte_i;
        endcase
    end
endmodule

// File: rtl/ctx_seq_fsm.sv
module ctx_seq_fsm
    import ctx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic suppress_i,
    input  logic ready_i,
    output logic load_o,
    output logic valid_o,
    output logic complete_o
);
    ctx_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_IDLE;
            ST_CONV: state_d = suppress_i ? ST_IDLE : ST_SEND;
            ST_SEND: if (ready_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (start_i) state_d = ST_CONV;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load_o     = (state_q == ST_CONV);
        valid_o    = (state_q == ST_SEND);
        complete_o = ((state_q == ST_SEND) && ready_i) ||
                     ((state_q == ST_CONV) && suppress_i && !start_i);
    end

    // R6
    send_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i && !start_i) |=> valid_o);

    // R11
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (load_o && !valid_o));
endmodule

// File: rtl/console_tx_port.sv
module console_tx_port
    import ctx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [1:0]        out_mode,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              irq,
    output logic [CNT_W-1:0]  sent_count
);
    logic              csr_wr, buf_wr, buf_lo, ie_n;
    logic [BYTE_W-1:0] buf_q, out_q, conv_byte;
    logic              ie_q, done_q, irq_q;
    logic              load, complete, suppress;
    logic [CNT_W-1:0]  cnt_q;

    assign csr_wr = bus_sel && bus_wr && !bus_addr[1] && !bus_addr[0];
    assign buf_wr = bus_sel && bus_wr && bus_addr[1];
    assign buf_lo = buf_wr && !bus_addr[0];
    assign ie_n   = csr_wr ? bus_wdata[IE_BIT] : ie_q;

    ctx_convert u_conv (
        .byte_i     (buf_q),
        .mode_i     (ctx_mode_e'(out_mode)),
        .byte_o     (conv_byte),
        .suppress_o (suppress)
    );

    ctx_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (buf_wr),
        .suppress_i (suppress),
        .ready_i    (tx_ready),
        .load_o     (load),
        .valid_o    (tx_valid),
        .complete_o (complete)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q  <= '0;
            out_q  <= '0;
            ie_q   <= 1'b0;
            done_q <= 1'b1;
            irq_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (csr_wr)   ie_q  <= bus_wdata[IE_BIT];
            if (buf_lo)   buf_q <= bus_wdata[BYTE_W-1:0];
            if (load)     out_q <= conv_byte;
            if (complete) cnt_q <= cnt_q + 1'b1;
            if (buf_wr) begin
                done_q <= 1'b0;
                irq_q  <= 1'b0;
            end else if (complete) begin
                done_q <= 1'b1;
                irq_q  <= ie_n;
            end else if (csr_wr) begin
                if (!bus_wdata[IE_BIT])       irq_q <= 1'b0;
                else if (done_q && !ie_q)     irq_q <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[1]) begin
            bus_rdata[BYTE_W-1:0] = buf_q;
        end else begin
            bus_rdata[DONE_BIT] = done_q;
            bus_rdata[IE_BIT]   = ie_q;
        end
    end

    assign tx_data    = out_q;
    assign irq        = irq_q;
    assign sent_count = cnt_q;

    // R7
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (done_q && ie_q));

    // R5
    buf_wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> (!done_q && !irq_q));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !buf_wr) |=> ($stable(tx_data) && tx_valid));

    // R6
    valid_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && done_q));
endmodule

// File: tb/console_tx_port_tb.sv
module console_tx_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'b00;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  out_mode = 2'b10;
    logic        tx_valid, tx_ready = 1'b0, irq;
    logic [7:0]  tx_data;
    logic [15:0] sent_count;

    int checks = 0, fails = 0, exp_count = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    console_tx_port #(.CNT_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .out_mode(out_mode), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .irq(irq), .sent_count(sent_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'b00;
    endtask

    task automatic read_word(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 2'b00;
    endtask

    function automatic int expect_byte(input int b, input int m);
        int e;
        e = b;
        if (m == 1 || m == 3) e = b % 128;
        if (m == 3 && e >= 97 && e <= 122) e = e - 32;
        return e;
    endfunction

    // one transfer with ready held low for 'stall' cycles
    task automatic send(input int b, input int m, input int stall, input string req);
        logic [15:0] r;
        bit sup;
        @(negedge clk);
        out_mode = m[1:0];
        bus_write(2'b10, 16'(b));
        sup = (m == 0) && ((b % 128) == 0 || (b % 128) == 127);
        @(negedge clk);
        if (sup) begin
            exp_count++;
            read_word(2'b00, r);
            check(!tx_valid && r[7] && sent_count == 16'(exp_count),
                  "R10", {tx_valid, r[7], sent_count}, {1'b0, 1'b1, 16'(exp_count)});
        end else begin
            check(tx_valid && tx_data == 8'(expect_byte(b, m)), req,
                  {tx_valid, tx_data}, {1'b1, 8'(expect_byte(b, m))});
            for (int i = 0; i < stall; i++) begin
                @(negedge clk);
                check(tx_valid && tx_data == 8'(expect_byte(b, m)), "R6",
                      {tx_valid, tx_data}, {1'b1, 8'(expect_byte(b, m))});
            end
            tx_ready = 1'b1;
            @(negedge clk);
            tx_ready = 1'b0;
            exp_count++;
            read_word(2'b00, r);
            check(!tx_valid && r[7] && sent_count == 16'(exp_count), "R7",
                  {tx_valid, r[7], sent_count}, {1'b0, 1'b1, 16'(exp_count)});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        read_word(2'b00, r);
        check(r == 16'h0080, "R2 csr", r, 16'h0080);
        read_word(2'b10, r);
        check(r == 16'h0000, "R2 buf", r, 0);
        check(!irq && !tx_valid && sent_count == 0, "R2 outs",
              {irq, tx_valid, sent_count}, 0);

        // R3 done not writable, odd csr write ignored
        bus_write(2'b00, 16'h0000);
        read_word(2'b00, r);
        check(r == 16'h0080, "R3 done", r, 16'h0080);
        bus_write(2'b01, 16'hFFFF);
        read_word(2'b00, r);
        check(r == 16'h0080, "R3 odd", r, 16'h0080);

        // R4 enable raises irq when done
        bus_write(2'b00, 16'hFFFF);
        read_word(2'b00, r);
        check(irq && r == 16'h00C0, "R4 raise", {irq, r}, {1'b1, 16'h00C0});
        bus_write(2'b00, 16'h0000);
        check(!irq, "R4 drop", irq, 0);
        bus_write(2'b00, 16'h0040);
        check(irq, "R4 raise2", irq, 1);

        // R5 buffer write drops irq; R7 irq after accept with enable
        send(8'h41, 2, 1, "R8");
        check(irq, "R7 irq", irq, 1);
        bus_write(2'b00, 16'h0000);

        // R1 buffer read-back, R5 odd byte write resends old byte
        read_word(2'b10, r);
        check(r == 16'h0041, "R1 buf", r, 16'h0041);
        @(negedge clk);
        bus_write(2'b11, 16'h5500);
        read_word(2'b00, r);
        check(r[7] == 1'b0, "R5 done clr", r[7], 0);
        read_word(2'b10, r);
        check(r == 16'h0041, "R5 odd keep", r, 16'h0041);
        @(negedge clk);
        check(tx_valid && tx_data == 8'h41, "R5 resend", {tx_valid, tx_data}, {1'b1, 8'h41});
        tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0; exp_count++;
        check(sent_count == 16'(exp_count), "R7 count", sent_count, exp_count);

        // R11 replace pending byte
        bus_write(2'b10, 16'h0031);
        @(negedge clk);
        check(tx_valid && tx_data == 8'h31, "R11 first", {tx_valid, tx_data}, {1'b1, 8'h31});
        bus_write(2'b10, 16'h0032);
        check(!tx_valid, "R11 gap", tx_valid, 0);
        @(negedge clk);
        check(tx_valid && tx_data == 8'h32, "R11 new", {tx_valid, tx_data}, {1'b1, 8'h32});
        tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0; exp_count++;
        check(sent_count == 16'(exp_count), "R11 once", sent_count, exp_count);

        // R8 R9 R10 sweep over all modes and bytes
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 256; b++) begin
                send(b, m, (b % 16 == 5) ? 2 : 0, (m == 3) ? "R9" : ((m == 0) ? "R10" : "R8"));
            end
        end

        // R12 reset mid-transfer
        out_mode = 2'b10;
        bus_write(2'b10, 16'h00A5);
        @(negedge clk);
        check(tx_valid, "R12 pre", tx_valid, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_word(2'b00, r);
        check(!tx_valid && r == 16'h0080 && sent_count == 0 && !irq, "R12 abort",
              {tx_valid, r, sent_count}, {1'b0, 16'h0080, 16'h0});
        read_word(2'b10, r);
        check(r == 16'h0000, "R12 buf", r, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule